// File: doc/BRIEF.md
# SPI Transmit Queue Controller

This block buffers outgoing SPI words between a host write port and a serial shift engine. The host offers one word per cycle on a push port. Each time the shift engine starts a frame, the word at the head of the queue moves into a shift-word register that the engine serializes. The queue depth is a parameter. An occupancy count is available at all times, and a flush command empties the queue in one cycle.

Two sticky status flags report events. A frame-complete flag is set whenever the engine reports the end of a frame. An underflow flag is set when the port is in slave mode and an external master starts a frame while nothing is queued. Software clears each flag by writing 1 to its clear input. Words pushed while the queue is full are discarded quietly, and no flag reports this.

Top module: `spi_txq_ctrl`

## Requirements
- R1: After reset the occupancy count is 0, the shift word is 0 and both flags are 0.
- R2: A push while the count is below DEPTH stores the word at the tail and raises the count by one in the next cycle. Words leave in the order they were pushed.
- R3: A push while the count equals DEPTH changes neither the stored words nor the count, and sets no flag.
- R4: A frame start while the count is non-zero copies the head word into the shift word and lowers the count by one in the next cycle.
- R5: A push and a frame start in the same cycle, with the queue neither empty nor full, leave the count unchanged and still move the head word into the shift word.
- R6: A frame-done pulse sets the frame-complete flag in the next cycle.
- R7: A 1 on a flag's clear input clears that flag in the next cycle. If a set event arrives in the same cycle as the clear, the flag stays 1.
- R8: A flush makes the count 0 in the next cycle. A push or frame start in the same cycle as the flush stores nothing and loads nothing.
- R9: In slave mode, a frame start while the count is 0 sets the underflow flag in the next cycle. In master mode the same event leaves the flag at 0.
- R10: A frame start while the count is 0 leaves the count and the shift word unchanged. A push in that same cycle is still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | Host offers a word this cycle |
| push_data | input | DW | Word to enqueue |
| flush | input | 1 | Empty the queue (write-1 command) |
| slave_mode | input | 1 | 1 = external master drives frames |
| frame_start | input | 1 | Shift engine begins a frame |
| frame_done | input | 1 | Shift engine finished a frame |
| clr_done_flag | input | 1 | Write-1-to-clear for the frame-complete flag |
| clr_uflow_flag | input | 1 | Write-1-to-clear for the underflow flag |
| shift_word | output | DW | Word most recently loaded for shifting |
| level | output | CNT_W | Number of queued words |
| done_flag | output | 1 | Frame-complete status |
| uflow_flag | output | 1 | Transmit underflow status |

## Verification
The hardest states to reach are the boundary cycles: a push arriving exactly when the queue is full, a push together with a frame start at both empty and middle occupancy, and a flush in the same cycle as a push. A scripted vector sequence fills the queue to DEPTH, offers one more word, and then drains while pushing. The discarded word must never appear in the shift word. The same script empties the queue, overlaps a push with a start on an empty queue, and collides a flush with a push. Directed steps then overlap flag clears with set events in both master and slave mode.

// File: rtl/spi_txq_pkg.sv
package spi_txq_pkg;
    typedef struct packed {
        logic done;
        logic uflow;
    } txq_flags_t;
endpackage

// File: rtl/spi_txq_store.sv
module spi_txq_store #(
    parameter int DEPTH = 4,
    parameter int DW    = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic          clr,
    output logic [DW-1:0] head
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DW-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] advance(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (clr) begin
            ptr_d = '0;
        end else begin
            if (wr_en) ptr_d.wr = advance(ptr_q.wr);
            if (rd_en) ptr_d.rd = advance(ptr_q.rd);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en && !clr) mem_q[ptr_q.wr] <= wr_data;
    end

    assign head = mem_q[ptr_q.rd];
endmodule

// File: rtl/spi_txq_flags.sv
module spi_txq_flags
    import spi_txq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_done,
    input  logic       set_uflow,
    input  logic       clr_done,
    input  logic       clr_uflow,
    output txq_flags_t flags
);
    txq_flags_t flg_d, flg_q;

    always_comb begin
        flg_d = flg_q;
        if (clr_done)  flg_d.done  = 1'b0;
        if (clr_uflow) flg_d.uflow = 1'b0;
        if (set_done)  flg_d.done  = 1'b1;
        if (set_uflow) flg_d.uflow = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flg_d;
    end

    assign flags = flg_q;

    assert_done_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_done |=> flags.done);
    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_uflow && !set_uflow) |=> !flags.uflow);
    assert_uflow_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_uflow |=> flags.uflow);
endmodule

// File: rtl/spi_txq_ctrl.sv
module spi_txq_ctrl
    import spi_txq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int DW    = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic [DW-1:0]    push_data,
    input  logic             flush,
    input  logic             slave_mode,
    input  logic             frame_start,
    input  logic             frame_done,
    input  logic             clr_done_flag,
    input  logic             clr_uflow_flag,
    output logic [DW-1:0]    shift_word,
    output logic [CNT_W-1:0] level,
    output logic             done_flag,
    output logic             uflow_flag
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    shw;
    } core_t;

    core_t core_d, core_q;
    logic [DW-1:0] head;
    logic empty, full, pop, push_ok;
    txq_flags_t flags;

    assign empty   = (core_q.cnt == '0);
    assign full    = (core_q.cnt == CNT_W'(DEPTH));
    assign pop     = frame_start && !empty && !flush;
    assign push_ok = push_valid && !full && !flush;

    always_comb begin
        core_d = core_q;
        if (flush) begin
            core_d.cnt = '0;
        end else begin
            core_d.cnt = core_q.cnt + CNT_W'(push_ok) - CNT_W'(pop);
        end
        if (pop) core_d.shw = head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    spi_txq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (push_ok),
        .wr_data(push_data),
        .rd_en  (pop),
        .clr    (flush),
        .head   (head)
    );

    spi_txq_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_done (frame_done),
        .set_uflow(frame_start && slave_mode && empty),
        .clr_done (clr_done_flag),
        .clr_uflow(clr_uflow_flag),
        .flags    (flags)
    );

    assign shift_word = core_q.shw;
    assign level      = core_q.cnt;
    assign done_flag  = flags.done;
    assign uflow_flag = flags.uflow;

    assert_level_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        core_q.cnt <= CNT_W'(DEPTH));
    assert_full_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && full && !frame_start && !flush) |=> (level == CNT_W'(DEPTH)));
    assert_load_head_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !empty && !flush) |=> (shift_word == $past(head)));
    assert_push_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && frame_start && !empty && !full && !flush) |=> $stable(level));
    assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    assert_empty_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && empty && !push_valid && !flush) |=> ($stable(shift_word) && level == '0));
endmodule

// File: tb/test_spi_txq_ctrl.sv
`timescale 1ns/1ps
module test_spi_txq_ctrl;
    localparam int DEPTH = 4;
    localparam int DW    = 16;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int NV    = 15;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic push_valid = 0, flush = 0, slave_mode = 0, frame_start = 0, frame_done = 0;
    logic clr_done_flag = 0, clr_uflow_flag = 0;
    logic [DW-1:0] push_data = '0;
    logic [DW-1:0] shift_word;
    logic [CW-1:0] level;
    logic done_flag, uflow_flag;
    int errors = 0, checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    spi_txq_ctrl #(.DEPTH(DEPTH), .DW(DW)) i_spi_txq_ctrl (.*);

    // {push, data, start, flush, expected level, expected shift word}
    localparam logic [39:0] VEC [NV] = '{
        {1'b1, 16'hA001, 1'b0, 1'b0, 5'd1, 16'h0000},  // R2
        {1'b1, 16'hA002, 1'b0, 1'b0, 5'd2, 16'h0000},
        {1'b1, 16'hA003, 1'b0, 1'b0, 5'd3, 16'h0000},
        {1'b1, 16'hA004, 1'b0, 1'b0, 5'd4, 16'h0000},
        {1'b1, 16'hA005, 1'b0, 1'b0, 5'd4, 16'h0000},  // R3 dropped
        {1'b0, 16'h0000, 1'b1, 1'b0, 5'd3, 16'hA001},  // R4
        {1'b1, 16'hB001, 1'b1, 1'b0, 5'd3, 16'hA002},  // R5
        {1'b0, 16'h0000, 1'b1, 1'b0, 5'd2, 16'hA003},
        {1'b0, 16'h0000, 1'b1, 1'b0, 5'd1, 16'hA004},
        {1'b0, 16'h0000, 1'b1, 1'b0, 5'd0, 16'hB001},  // R3 A005 never seen
        {1'b0, 16'h0000, 1'b1, 1'b0, 5'd0, 16'hB001},  // R10
        {1'b1, 16'hC001, 1'b1, 1'b0, 5'd1, 16'hB001},  // R10 push kept
        {1'b1, 16'hC002, 1'b0, 1'b1, 5'd0, 16'hB001},  // R8
        {1'b1, 16'hC003, 1'b0, 1'b0, 5'd1, 16'hB001},
        {1'b0, 16'h0000, 1'b1, 1'b0, 5'd0, 16'hC003}   // R8 C001/C002 gone
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        push_valid = 0; flush = 0; frame_start = 0; frame_done = 0;
        clr_done_flag = 0; clr_uflow_flag = 0;
    endtask

    initial begin
        #100000;
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 level", 32'(level), 0);
        chk("R1 shift", 32'(shift_word), 0);
        chk("R1 flags", {30'd0, done_flag, uflow_flag}, 0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            push_valid = VEC[i][39]; push_data = VEC[i][38:23];
            frame_start = VEC[i][22]; flush = VEC[i][21];
            cycle();
            chk($sformatf("R2-table row %0d level", i), 32'(level), 32'(VEC[i][20:16]));
            chk($sformatf("R4 row %0d shift", i), 32'(shift_word), 32'(VEC[i][15:0]));
            if (i == 4) chk("R3 no flag on full push", {30'd0, done_flag, uflow_flag}, 0);
            if (i == 10) chk("R9 master empty start no underflow", 32'(uflow_flag), 0);
        end
        idle();

        // R6 / R7 frame-complete flag
        frame_done = 1; cycle();
        chk("R6 done set", 32'(done_flag), 1);
        idle(); frame_done = 1; clr_done_flag = 1; cycle();
        chk("R7 set wins over clear", 32'(done_flag), 1);
        idle(); clr_done_flag = 1; cycle();
        chk("R7 clear", 32'(done_flag), 0);

        // R9 slave underflow on empty queue
        idle(); slave_mode = 1; frame_start = 1; cycle();
        chk("R9 underflow set", 32'(uflow_flag), 1);
        chk("R10 shift unchanged", 32'(shift_word), 32'hC003);
        idle(); frame_start = 1; clr_uflow_flag = 1; cycle();
        chk("R7 uflow set wins", 32'(uflow_flag), 1);
        idle(); clr_uflow_flag = 1; cycle();
        chk("R7 uflow clear", 32'(uflow_flag), 0);
        // slave start with data queued: no underflow
        idle(); push_valid = 1; push_data = 16'hD001; cycle();
        idle(); frame_start = 1; cycle();
        chk("R9 no underflow when queued", 32'(uflow_flag), 0);
        chk("R4 slave load", 32'(shift_word), 32'hD001);
        idle();

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule